// File: doc/BRIEF.md
# Dual-CPU Phase-Interleaved Memory Decoder

This block sits between two 8-bit processors with 16-bit addresses and their memories. Both processors run from one clock, and each owns alternate cycles of it: CPU A takes the first cycle after reset and every second cycle after that, and CPU B takes the cycles in between. Because only the owner of the current cycle can reach the shared memory bus, the two never contend for it.

For each processor the block sorts every address into one of four places. The bottom 512 bytes (zero page and stack) go to a RAM that belongs to that processor alone. The top page holds a ROM that belongs to that processor alone, so each one fetches its own vectors and boot stub. The page just below the ROM is a private control page. Everything else goes through four per-processor 4-bit bank registers into a 256 KiB shared RAM outside the block. The control page holds the bank registers and a doorbell. A processor leaves a message in shared RAM and then rings the doorbell, which pulls the other processor's NMI low. That NMI stays low until the other processor acknowledges it.

Top module: `dual_phase_mem_decoder`

## Requirements
- R1: `bus_owner` is 0 (CPU A) in the first cycle after reset is released, and it toggles on every clock edge after that. A processor's inputs are sampled only in cycles that it owns.
- R2: `sh_we`, `sh_addr` and `sh_wdata` are nonzero only when the current owner is accessing the shared range. `sh_we` is 1 only when that owner is writing there. In every other cycle all three are 0.
- R3: Addresses 0x0000–0x01FF reach a 512-byte RAM private to each processor. A write there by one processor never changes what the other reads at the same address.
- R4: Addresses 0xFF00–0xFFFF read a private ROM whose byte equals the address low byte XOR 0x3C for CPU A and XOR 0xC3 for CPU B. Writes to this range have no effect.
- R5: An address in 0x0200–0xFDFF maps to the 18-bit shared address {bank, addr[13:0]}. The bank is the issuing processor's bank register that addr[15:14] selects.
- R6: Each processor's bank register n (n = 0..3) sits at 0xFE00+n in that processor's control page. Bits [3:0] of a write set it, and a read returns it zero-extended. Each processor's registers are separate from the other processor's.
- R7: A write of any value to 0xFE10 sets a sticky request for the other processor. That processor's active-low NMI goes to 0 at the clock edge that ends the writing cycle and stays there.
- R8: A write to 0xFE11 clears the writer's own request, and its NMI returns to 1 at the end of that cycle. A read of 0xFE11 returns the request flag in bit 0.
- R9: Read data for a processor is captured at the clock edge that ends its own cycle. It holds unchanged through the other processor's cycle.
- R10: After reset every bank register is 0 and both NMI outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both processors |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | 16 | CPU A address |
| a_we | input | 1 | CPU A write strobe |
| a_wdata | input | 8 | CPU A write data |
| a_rdata | output | 8 | CPU A registered read data |
| a_nmi_n | output | 1 | CPU A active-low NMI |
| b_addr | input | 16 | CPU B address |
| b_we | input | 1 | CPU B write strobe |
| b_wdata | input | 8 | CPU B write data |
| b_rdata | output | 8 | CPU B registered read data |
| b_nmi_n | output | 1 | CPU B active-low NMI |
| bus_owner | output | 1 | Current cycle owner: 0 = A, 1 = B |
| sh_addr | output | 18 | Shared RAM address |
| sh_we | output | 1 | Shared RAM write enable |
| sh_wdata | output | 8 | Shared RAM write data |
| sh_rdata | input | 8 | Shared RAM read data, combinational from sh_addr |

## Verification
The assertions assume that the shared RAM returns `sh_rdata` in the same cycle as `sh_addr`. They also assume that each processor's address, strobe and data are valid for the whole of its own cycle. Inputs presented in the other processor's cycle may be anything. The bench models the shared RAM as a combinational array that is written at the clock edge. It drives each processor's inputs at the falling edge inside that processor's cycle and clears them after the closing edge. One scenario deliberately drives CPU A's write strobe in CPU B's cycle, to show that it is ignored.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
    localparam int DPD_ADDR_W   = 16;
    localparam int DPD_DATA_W   = 8;
    localparam int DPD_BANK_W   = 4;
    localparam int DPD_WIN_BITS = 2;
    localparam int DPD_RAM_B    = 512;

    localparam logic [7:0] PAGE_CTRL = 8'hFE;
    localparam logic [7:0] PAGE_ROM  = 8'hFF;
    localparam logic [7:0] OFS_RING  = 8'h10;
    localparam logic [7:0] OFS_ACK   = 8'h11;

    typedef enum logic [1:0] {
        RG_RAM    = 2'd0,
        RG_CTRL   = 2'd1,
        RG_ROM    = 2'd2,
        RG_SHARED = 2'd3
    } region_e;
endpackage

// File: rtl/dpd_decode.sv
module dpd_decode
    import dpd_pkg::*;
#(
    parameter int ADDR_W   = DPD_ADDR_W,
    parameter int BANK_W   = DPD_BANK_W,
    parameter int WIN_BITS = DPD_WIN_BITS,
    parameter int RAM_B    = DPD_RAM_B
) (
    input  logic [ADDR_W-1:0]                       addr,
    input  logic [(1<<WIN_BITS)-1:0][BANK_W-1:0]    banks,
    output region_e                                 region,
    output logic [BANK_W+ADDR_W-WIN_BITS-1:0]       phys
);
    localparam int OFS_W = ADDR_W - WIN_BITS;

    logic [7:0]          page;
    logic [WIN_BITS-1:0] win;

    assign page = addr[ADDR_W-1 -: 8];
    assign win  = addr[ADDR_W-1 -: WIN_BITS];

    always_comb begin
        if (addr < ADDR_W'(RAM_B))     region = RG_RAM;
        else if (page == PAGE_ROM)     region = RG_ROM;
        else if (page == PAGE_CTRL)    region = RG_CTRL;
        else                           region = RG_SHARED;
    end

    assign phys = {banks[win], addr[OFS_W-1:0]};
endmodule

// File: rtl/dpd_cpu_port.sv
module dpd_cpu_port
    import dpd_pkg::*;
#(
    parameter int         ADDR_W   = DPD_ADDR_W,
    parameter int         DATA_W   = DPD_DATA_W,
    parameter int         BANK_W   = DPD_BANK_W,
    parameter int         WIN_BITS = DPD_WIN_BITS,
    parameter int         RAM_B    = DPD_RAM_B,
    parameter logic [7:0] ROM_KEY  = 8'h3C
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                active,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic                                we,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic [DATA_W-1:0]                   sh_rdata,
    input  logic                                ring_in,
    output logic [DATA_W-1:0]                   rdata,
    output logic                                nmi_n,
    output logic                                ring_out,
    output logic                                sh_valid,
    output logic                                sh_we,
    output logic [BANK_W+ADDR_W-WIN_BITS-1:0]   sh_addr
);
    localparam int NUM_WIN = 1 << WIN_BITS;
    localparam int PHYS_W  = BANK_W + ADDR_W - WIN_BITS;
    localparam int RAM_AW  = $clog2(RAM_B);

    typedef struct packed {
        logic [NUM_WIN-1:0][BANK_W-1:0] bank;
        logic                           pend;
        logic [DATA_W-1:0]              rdata;
    } port_state_t;

    port_state_t st_d, st_q;
    region_e     region;
    logic [PHYS_W-1:0] phys;
    logic [7:0]  ctrl_ofs;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] ram [RAM_B];

    dpd_decode #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIN_BITS(WIN_BITS), .RAM_B(RAM_B)
    ) u_decode (
        .addr  (addr),
        .banks (st_q.bank),
        .region(region),
        .phys  (phys)
    );

    assign ctrl_ofs = addr[7:0];

    always_comb begin
        rd_mux = '0;
        unique case (region)
            RG_RAM:    rd_mux = ram[addr[RAM_AW-1:0]];
            RG_ROM:    rd_mux = DATA_W'(addr[7:0] ^ ROM_KEY);
            RG_SHARED: rd_mux = sh_rdata;
            RG_CTRL: begin
                if (ctrl_ofs < 8'(NUM_WIN))
                    rd_mux = DATA_W'(st_q.bank[ctrl_ofs[WIN_BITS-1:0]]);
                else if (ctrl_ofs == OFS_ACK)
                    rd_mux = DATA_W'(st_q.pend);
            end
            default:   rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        ring_out = 1'b0;
        if (active) begin
            st_d.rdata = rd_mux;
            if (we && region == RG_CTRL) begin
                if (ctrl_ofs < 8'(NUM_WIN))
                    st_d.bank[ctrl_ofs[WIN_BITS-1:0]] = wdata[BANK_W-1:0];
                else if (ctrl_ofs == OFS_RING)
                    ring_out = 1'b1;
                else if (ctrl_ofs == OFS_ACK)
                    st_d.pend = 1'b0;
            end
        end
        if (ring_in)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (active && we && region == RG_RAM)
            ram[addr[RAM_AW-1:0]] <= wdata;
    end

    assign rdata    = st_q.rdata;
    assign nmi_n    = ~st_q.pend;
    assign sh_valid = active && (region == RG_SHARED);
    assign sh_we    = sh_valid && we;
    assign sh_addr  = phys;
endmodule

// File: rtl/dpd_phase_mux.sv
module dpd_phase_mux #(
    parameter int PHYS_W = 18,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   req_valid,
    input  logic [1:0]                   req_we,
    input  logic [1:0][PHYS_W-1:0]       req_addr,
    input  logic [1:0][DATA_W-1:0]       req_wdata,
    output logic [1:0]                   active,
    output logic                         owner,
    output logic [PHYS_W-1:0]            sh_addr,
    output logic                         sh_we,
    output logic [DATA_W-1:0]            sh_wdata
);
    typedef struct packed {
        logic owner;
    } phase_state_t;

    phase_state_t ph_d, ph_q;

    always_comb begin
        ph_d       = ph_q;
        ph_d.owner = ~ph_q.owner;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign owner  = ph_q.owner;
    assign active = {ph_q.owner, ~ph_q.owner};

    always_comb begin
        sh_addr  = '0;
        sh_we    = 1'b0;
        sh_wdata = '0;
        if (req_valid[ph_q.owner]) begin
            sh_addr = req_addr[ph_q.owner];
            sh_we   = req_we[ph_q.owner];
            if (req_we[ph_q.owner])
                sh_wdata = req_wdata[ph_q.owner];
        end
    end
endmodule

// File: rtl/dual_phase_mem_decoder.sv
module dual_phase_mem_decoder
    import dpd_pkg::*;
#(
    parameter int ADDR_W   = DPD_ADDR_W,
    parameter int DATA_W   = DPD_DATA_W,
    parameter int BANK_W   = DPD_BANK_W,
    parameter int WIN_BITS = DPD_WIN_BITS,
    parameter int RAM_B    = DPD_RAM_B,
    parameter int PHYS_W   = BANK_W + ADDR_W - WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_nmi_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_nmi_n,
    output logic              bus_owner,
    output logic [PHYS_W-1:0] sh_addr,
    output logic              sh_we,
    output logic [DATA_W-1:0] sh_wdata,
    input  logic [DATA_W-1:0] sh_rdata
);
    logic [1:0][ADDR_W-1:0] cpu_addr;
    logic [1:0]             cpu_we;
    logic [1:0][DATA_W-1:0] cpu_wdata;
    logic [1:0][DATA_W-1:0] cpu_rdata;
    logic [1:0]             cpu_nmi_n;
    logic [1:0]             ring;
    logic [1:0]             active;
    logic [1:0]             req_valid;
    logic [1:0]             req_we;
    logic [1:0][PHYS_W-1:0] req_addr;

    assign cpu_addr  = {b_addr, a_addr};
    assign cpu_we    = {b_we, a_we};
    assign cpu_wdata = {b_wdata, a_wdata};

    for (genvar g = 0; g < 2; g++) begin : g_port
        dpd_cpu_port #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
            .WIN_BITS(WIN_BITS), .RAM_B(RAM_B),
            .ROM_KEY((g == 0) ? 8'h3C : 8'hC3)
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active[g]),
            .addr    (cpu_addr[g]),
            .we      (cpu_we[g]),
            .wdata   (cpu_wdata[g]),
            .sh_rdata(sh_rdata),
            .ring_in (ring[1-g]),
            .rdata   (cpu_rdata[g]),
            .nmi_n   (cpu_nmi_n[g]),
            .ring_out(ring[g]),
            .sh_valid(req_valid[g]),
            .sh_we   (req_we[g]),
            .sh_addr (req_addr[g])
        );
    end

    dpd_phase_mux #(.PHYS_W(PHYS_W), .DATA_W(DATA_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_we   (req_we),
        .req_addr (req_addr),
        .req_wdata(cpu_wdata),
        .active   (active),
        .owner    (bus_owner),
        .sh_addr  (sh_addr),
        .sh_we    (sh_we),
        .sh_wdata (sh_wdata)
    );

    assign a_rdata = cpu_rdata[0];
    assign b_rdata = cpu_rdata[1];
    assign a_nmi_n = cpu_nmi_n[0];
    assign b_nmi_n = cpu_nmi_n[1];
endmodule

// File: rtl/dpd_checker.sv
module dpd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] a_addr,
    input logic        a_we,
    input logic [7:0]  a_rdata,
    input logic        a_nmi_n,
    input logic [15:0] b_addr,
    input logic        b_we,
    input logic [7:0]  b_rdata,
    input logic        b_nmi_n,
    input logic        bus_owner,
    input logic        sh_we
);
    assert_owner_a_to_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_owner |=> bus_owner);
    assert_owner_b_to_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_owner |=> !bus_owner);

    assert_shared_we_from_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_we |-> (bus_owner ? b_we : a_we));

    assert_b_nmi_from_a_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_nmi_n) |-> $past(!bus_owner && a_we && a_addr == 16'hFE10));
    assert_a_nmi_from_b_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_nmi_n) |-> $past(bus_owner && b_we && b_addr == 16'hFE10));

    assert_b_nmi_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_nmi_n) |-> $past(bus_owner && b_we && b_addr == 16'hFE11));
    assert_a_nmi_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_nmi_n) |-> $past(!bus_owner && a_we && a_addr == 16'hFE11));

    assert_a_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_owner && $past(rst_n)) |-> $stable(a_rdata));
    assert_b_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_owner && $past(rst_n) && $past(bus_owner, 2) == 1'b0) |-> $stable(b_rdata));
endmodule

bind dual_phase_mem_decoder dpd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_addr   (a_addr),
    .a_we     (a_we),
    .a_rdata  (a_rdata),
    .a_nmi_n  (a_nmi_n),
    .b_addr   (b_addr),
    .b_we     (b_we),
    .b_rdata  (b_rdata),
    .b_nmi_n  (b_nmi_n),
    .bus_owner(bus_owner),
    .sh_we    (sh_we)
);

// File: tb/dual_phase_mem_decoder_tb.sv
`timescale 1ns/1ps
module dual_phase_mem_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_addr = '0, b_addr = '0;
    logic        a_we = 1'b0, b_we = 1'b0;
    logic [7:0]  a_wdata = '0, b_wdata = '0;
    logic [7:0]  a_rdata, b_rdata;
    logic        a_nmi_n, b_nmi_n, bus_owner;
    logic [17:0] sh_addr;
    logic        sh_we;
    logic [7:0]  sh_wdata, sh_rdata;
    logic [7:0]  shm [1024];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_phase_mem_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_nmi_n(a_nmi_n),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_nmi_n(b_nmi_n),
        .bus_owner(bus_owner), .sh_addr(sh_addr), .sh_we(sh_we),
        .sh_wdata(sh_wdata), .sh_rdata(sh_rdata)
    );

    assign sh_rdata = shm[{sh_addr[17:14], sh_addr[5:0]}];
    always @(posedge clk) if (sh_we) shm[{sh_addr[17:14], sh_addr[5:0]}] <= sh_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input bit cpu, input logic [15:0] ad, input bit w, input logic [7:0] wd,
                       output logic [7:0] rd, output logic [17:0] sa, output logic sw);
        @(negedge clk);
        if (bus_owner != cpu) @(negedge clk);
        if (cpu) begin b_addr = ad; b_we = w; b_wdata = wd; end
        else     begin a_addr = ad; a_we = w; a_wdata = wd; end
        #0.5;
        sa = sh_addr;
        sw = sh_we;
        @(posedge clk);
        #1;
        rd = cpu ? b_rdata : a_rdata;
        if (cpu) begin b_addr = '0; b_we = 1'b0; b_wdata = '0; end
        else     begin a_addr = '0; a_we = 1'b0; a_wdata = '0; end
    endtask

    task automatic t_reset;
        logic [7:0] rd; logic [17:0] sa; logic sw;
        chk("R10 a_nmi_n", a_nmi_n, 1);
        chk("R10 b_nmi_n", b_nmi_n, 1);
        @(negedge clk);
        chk("R1 first owner", bus_owner, 0);
        @(negedge clk);
        chk("R1 second owner", bus_owner, 1);
        @(negedge clk);
        chk("R1 third owner", bus_owner, 0);
        for (int n = 0; n < 4; n++) begin
            acc(0, 16'hFE00 + 16'(n), 0, 0, rd, sa, sw);
            chk("R10 A bank reset", rd, 0);
            acc(1, 16'hFE00 + 16'(n), 0, 0, rd, sa, sw);
            chk("R10 B bank reset", rd, 0);
        end
    endtask

    task automatic t_private;
        logic [7:0] rd; logic [17:0] sa; logic sw;
        acc(0, 16'h0050, 1, 8'h11, rd, sa, sw);
        chk("R2 no shared we on private", sw, 0);
        acc(1, 16'h0050, 1, 8'h22, rd, sa, sw);
        acc(0, 16'h01FF, 1, 8'hA1, rd, sa, sw);
        acc(1, 16'h01FF, 1, 8'hB2, rd, sa, sw);
        acc(0, 16'h0050, 0, 0, rd, sa, sw);
        chk("R3 A zero page", rd, 8'h11);
        chk("R2 idle shared addr", sa, 0);
        acc(1, 16'h0050, 0, 0, rd, sa, sw);
        chk("R3 B zero page", rd, 8'h22);
        acc(0, 16'h01FF, 0, 0, rd, sa, sw);
        chk("R3 A stack top", rd, 8'hA1);
        @(posedge clk); #1;
        chk("R9 A rdata held in B cycle", a_rdata, 8'hA1);
        acc(1, 16'h01FF, 0, 0, rd, sa, sw);
        chk("R3 B stack top", rd, 8'hB2);
    endtask

    task automatic t_rom;
        logic [7:0] rd; logic [17:0] sa; logic sw;
        acc(0, 16'hFFFC, 0, 0, rd, sa, sw);
        chk("R4 A rom", rd, 8'hFC ^ 8'h3C);
        acc(1, 16'hFFFC, 0, 0, rd, sa, sw);
        chk("R4 B rom", rd, 8'hFC ^ 8'hC3);
        acc(0, 16'hFF00, 1, 8'h99, rd, sa, sw);
        chk("R2 rom write not shared", sw, 0);
        acc(0, 16'hFF00, 0, 0, rd, sa, sw);
        chk("R4 A rom write ignored", rd, 8'h3C);
    endtask

    task automatic t_banks;
        logic [7:0] rd; logic [17:0] sa; logic sw;
        acc(0, 16'h0200, 0, 0, rd, sa, sw);
        chk("R5 window0 bank0", sa, 18'h00200);
        acc(0, 16'hFE01, 1, 8'hF5, rd, sa, sw);
        acc(0, 16'hFE01, 0, 0, rd, sa, sw);
        chk("R6 A bank1 readback", rd, 8'h05);
        acc(1, 16'hFE01, 0, 0, rd, sa, sw);
        chk("R6 B bank1 separate", rd, 8'h00);
        acc(0, 16'h4123, 1, 8'h77, rd, sa, sw);
        chk("R5 A remapped addr", sa, 18'h14123);
        chk("R2 A shared we", sw, 1);
        acc(1, 16'h4123, 0, 0, rd, sa, sw);
        chk("R5 B unmapped addr", sa, 18'h00123);
        chk("R5 B other bank data", rd, 8'h00);
        acc(1, 16'hFE01, 1, 8'h05, rd, sa, sw);
        acc(1, 16'h4123, 0, 0, rd, sa, sw);
        chk("R5 B remapped addr", sa, 18'h14123);
        chk("R5 B sees A message", rd, 8'h77);
        acc(0, 16'hFE03, 1, 8'h0F, rd, sa, sw);
        acc(0, 16'hFD00, 1, 8'h5A, rd, sa, sw);
        chk("R5 window3 top bank", sa, 18'h3FD00);
    endtask

    task automatic t_off_phase;
        logic [7:0] rd; logic [17:0] sa; logic sw;
        @(negedge clk);
        if (bus_owner != 1'b1) @(negedge clk);
        a_addr = 16'h8000; a_we = 1'b1; a_wdata = 8'hEE;
        b_addr = 16'h0010; b_we = 1'b0;
        #0.5;
        chk("R2 off-phase A write not on bus", sh_we, 0);
        chk("R1 off-phase A addr not on bus", sh_addr, 0);
        @(posedge clk); #1;
        a_we = 1'b0; a_addr = 16'h0000;
        acc(0, 16'h8000, 0, 0, rd, sa, sw);
        chk("R1 off-phase write ignored", rd, 8'h00);
    endtask

    task automatic t_doorbell;
        logic [7:0] rd; logic [17:0] sa; logic sw;
        acc(0, 16'h4000, 1, 8'hC1, rd, sa, sw);
        acc(0, 16'hFE10, 1, 8'h00, rd, sa, sw);
        chk("R7 B nmi asserted", b_nmi_n, 0);
        chk("R7 A nmi untouched", a_nmi_n, 1);
        repeat (5) @(posedge clk);
        #1;
        chk("R7 B nmi sticky", b_nmi_n, 0);
        acc(1, 16'hFE11, 0, 0, rd, sa, sw);
        chk("R8 B pending read", rd, 8'h01);
        acc(1, 16'hFE11, 1, 0, rd, sa, sw);
        chk("R8 B nmi released", b_nmi_n, 1);
        acc(1, 16'hFE11, 0, 0, rd, sa, sw);
        chk("R8 B pending cleared", rd, 8'h00);
        acc(1, 16'hFE10, 1, 8'h00, rd, sa, sw);
        chk("R7 A nmi asserted", a_nmi_n, 0);
        acc(0, 16'hFE11, 1, 0, rd, sa, sw);
        chk("R8 A nmi released", a_nmi_n, 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) shm[i] = 8'h00;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_private();
        t_rom();
        t_banks();
        t_off_phase();
        t_doorbell();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule